// File: doc/BRIEF.md
# Address Translation Window Register File

This block holds two banks of programmable address translation windows for a PCIe root port. One bank serves outbound traffic and the other inbound traffic. Software reaches every window through a single index register, which names both the window number and the bank. Each window carries a 64-bit base, a 64-bit target, a 32-bit limit and two control words. A window either translates memory addresses or routes configuration accesses to a bus and device/function taken from its target.

A lookup port takes a bank flag and a 64-bit address. One cycle later it returns whether a window matched, which window won, the translated address, and whether the match is a memory or a configuration access. For a configuration match it also returns the bus and device/function numbers. Programming changes are staged: a window's decode only picks up its new settings when its second control word is written. Changing a base, target or limit therefore never exposes a half-updated window to live lookups.

Top module: `atu_xlate_regs`

## Requirements
- R1: The index register (word offset 0) keeps the window number in bits WIN_W-1:0, masked with NUM_WIN-1 on write, and the bank flag in bit 31 (1 = inbound). All other bits read as zero.
- R2: Word offsets 1 to 7 (base low, base high, target low, target high, limit, control 0, control 1) read and write only the window named by the current index and bank flag.
- R3: A write to one 32-bit half of the base or of the target leaves the other half unchanged.
- R4: After reset, every window reads base 0, target 0, limit 0xFFFFFFFF and control 0 = 0. Inbound window 0 has control 1 = 0x80000000 (enabled), and every other window has control 1 = 0.
- R5: A lookup hits a window when its active enable (control 1 bit 31) is set and base <= address <= {base[63:32], limit}, both ends included.
- R6: Control 0 equal to 0 marks a memory window. A memory hit returns target + (address - base) with res_cfg low.
- R7: Any nonzero control 0 marks a configuration window. A hit returns res_cfg high, the offset (address - base) masked to its low CFG_OFF_W bits, res_bus = target[31:24] and res_devfn = target[23:16].
- R8: Writes to base, target, limit or control 0 do not change lookup results until control 1 of that window is written. That write makes all of the window's current settings active together.
- R9: When several enabled windows match, the lowest window number wins, and it is reported on res_win.
- R10: lk_inbound selects which bank is searched. A miss gives res_hit, res_cfg, res_addr, res_bus and res_devfn all zero.
- R11: A read returns its data on reg_rdata in the cycle after reg_rd. Unimplemented offsets read as zero.
- R12: Lookup results appear one cycle after lk_valid, with res_valid high in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 6 | Register word offset |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, one cycle after reg_rd |
| lk_valid | input | 1 | Lookup request |
| lk_inbound | input | 1 | Bank searched: 1 = inbound, 0 = outbound |
| lk_addr | input | 64 | Address to translate |
| res_valid | output | 1 | Lookup result valid |
| res_hit | output | 1 | A window matched |
| res_cfg | output | 1 | Match is a configuration access |
| res_win | output | WIN_W | Number of the winning window |
| res_addr | output | 64 | Translated address or masked configuration offset |
| res_bus | output | 8 | Bus number for configuration hits |
| res_devfn | output | 8 | Device/function for configuration hits |

## Verification
Lookups probe both ends of a window and the addresses one below its base and one above its limit. This shows whether the inclusive bounds are computed correctly. Overlapping windows are probed inside the overlap and on each side of it, then again after the lower window is disabled, which separates priority order from plain matching. Target changes are made before and after a control 1 write and looked up in between, to show whether staging holds. The same addresses are also sent to the other bank, to show whether the two banks are kept apart.

// File: rtl/atu_pkg.sv
package atu_pkg;
  typedef struct packed {
    logic [63:0] base;
    logic [63:0] target;
    logic [31:0] limit;
    logic [31:0] ctrl0;
    logic [31:0] ctrl1;
  } atu_win_t;

  typedef enum logic [2:0] {
    F_BASE_LO, F_BASE_HI, F_TGT_LO, F_TGT_HI, F_LIMIT, F_CTRL0, F_CTRL1
  } atu_field_e;

  localparam logic [5:0] OFF_IDX     = 6'd0;
  localparam logic [5:0] OFF_BASE_LO = 6'd1;
  localparam logic [5:0] OFF_BASE_HI = 6'd2;
  localparam logic [5:0] OFF_TGT_LO  = 6'd3;
  localparam logic [5:0] OFF_TGT_HI  = 6'd4;
  localparam logic [5:0] OFF_LIMIT   = 6'd5;
  localparam logic [5:0] OFF_CTRL0   = 6'd6;
  localparam logic [5:0] OFF_CTRL1   = 6'd7;

  localparam int          EN_BIT   = 31;
  localparam int          DIR_BIT  = 31;
  localparam logic [31:0] TYPE_MEM = 32'd0;
endpackage

// File: rtl/atu_win.sv
module atu_win
  import atu_pkg::*;
#(
  parameter bit INIT_EN = 1'b0
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       wr_en,
  input  atu_field_e wr_fld,
  input  logic [31:0] wdata,
  output atu_win_t   prog,
  output atu_win_t   act
);
  localparam atu_win_t RST_V = '{
    base:   64'd0,
    target: 64'd0,
    limit:  32'hFFFF_FFFF,
    ctrl0:  TYPE_MEM,
    ctrl1:  (INIT_EN ? 32'h8000_0000 : 32'h0)
  };

  always_ff @(posedge clk) begin
    if (rst) begin
      prog <= RST_V;
      act  <= RST_V;
    end else if (wr_en) begin
      case (wr_fld)
        F_BASE_LO: prog.base[31:0]    <= wdata;
        F_BASE_HI: prog.base[63:32]   <= wdata;
        F_TGT_LO:  prog.target[31:0]  <= wdata;
        F_TGT_HI:  prog.target[63:32] <= wdata;
        F_LIMIT:   prog.limit         <= wdata;
        F_CTRL0:   prog.ctrl0         <= wdata;
        F_CTRL1: begin
          prog.ctrl1 <= wdata;
          act        <= '{base: prog.base, target: prog.target, limit: prog.limit,
                          ctrl0: prog.ctrl0, ctrl1: wdata};
        end
        default: ;
      endcase
    end
  end

  // R8: the active decode only moves on a control 1 write
  p_act_hold_r8: assert property (@(posedge clk) disable iff (rst)
    !(wr_en && wr_fld == F_CTRL1) |=> $stable(act));
  // R3: half writes keep the opposite half
  p_base_half_r3: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_fld == F_BASE_LO) |=> $stable(prog.base[63:32]));
  p_tgt_half_r3: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_fld == F_TGT_HI) |=> $stable(prog.target[31:0]));
endmodule

// File: rtl/atu_lookup.sv
module atu_lookup
  import atu_pkg::*;
#(
  parameter int NUM_WIN   = 16,
  parameter int CFG_OFF_W = 12,
  localparam int WIN_W    = $clog2(NUM_WIN)
) (
  input  atu_win_t [NUM_WIN-1:0] wins,
  input  logic [63:0]            addr,
  output logic                   hit,
  output logic [WIN_W-1:0]       win,
  output logic                   cfg,
  output logic [63:0]            xaddr,
  output logic [7:0]             bus,
  output logic [7:0]             devfn
);
  logic [NUM_WIN-1:0] match;
  logic [NUM_WIN-1:0] unused_ctl;

  for (genvar i = 0; i < NUM_WIN; i++) begin : g_cmp
    assign match[i] = wins[i].ctrl1[EN_BIT] &&
                      (addr >= wins[i].base) &&
                      (addr <= {wins[i].base[63:32], wins[i].limit});
    assign unused_ctl[i] = ^wins[i].ctrl1[EN_BIT-1:0];
  end

  logic [63:0] sel_base, sel_tgt, offset;
  logic [31:0] sel_type;

  always_comb begin
    hit      = 1'b0;
    win      = '0;
    sel_base = '0;
    sel_tgt  = '0;
    sel_type = '0;
    for (int i = NUM_WIN - 1; i >= 0; i--) begin
      if (match[i]) begin
        hit      = 1'b1;
        win      = WIN_W'(i);
        sel_base = wins[i].base;
        sel_tgt  = wins[i].target;
        sel_type = wins[i].ctrl0;
      end
    end
    offset = addr - sel_base;
    cfg    = hit && (sel_type != TYPE_MEM);
    if (!hit)      xaddr = '0;
    else if (cfg)  xaddr = {{(64-CFG_OFF_W){1'b0}}, offset[CFG_OFF_W-1:0]};
    else           xaddr = sel_tgt + offset;
    bus   = cfg ? sel_tgt[31:24] : 8'd0;
    devfn = cfg ? sel_tgt[23:16] : 8'd0;
  end
endmodule

// File: rtl/atu_xlate_regs.sv
module atu_xlate_regs
  import atu_pkg::*;
#(
  parameter int NUM_WIN   = 16,
  parameter int CFG_OFF_W = 12,
  localparam int WIN_W    = $clog2(NUM_WIN)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [5:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              lk_valid,
  input  logic              lk_inbound,
  input  logic [63:0]       lk_addr,
  output logic              res_valid,
  output logic              res_hit,
  output logic              res_cfg,
  output logic [WIN_W-1:0]  res_win,
  output logic [63:0]       res_addr,
  output logic [7:0]        res_bus,
  output logic [7:0]        res_devfn
);
  localparam logic [WIN_W-1:0] WIN_MASK = WIN_W'(NUM_WIN - 1);

  logic [WIN_W-1:0] cur_win;
  logic             cur_in;

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_win <= '0;
      cur_in  <= 1'b0;
    end else if (reg_wr && reg_addr == OFF_IDX) begin
      cur_win <= reg_wdata[WIN_W-1:0] & WIN_MASK;
      cur_in  <= reg_wdata[DIR_BIT];
    end
  end

  logic       fld_ok;
  atu_field_e fld;
  always_comb begin
    fld_ok = 1'b1;
    fld    = F_BASE_LO;
    case (reg_addr)
      OFF_BASE_LO: fld = F_BASE_LO;
      OFF_BASE_HI: fld = F_BASE_HI;
      OFF_TGT_LO:  fld = F_TGT_LO;
      OFF_TGT_HI:  fld = F_TGT_HI;
      OFF_LIMIT:   fld = F_LIMIT;
      OFF_CTRL0:   fld = F_CTRL0;
      OFF_CTRL1:   fld = F_CTRL1;
      default:     fld_ok = 1'b0;
    endcase
  end

  atu_win_t [NUM_WIN-1:0] prog_q [2];
  atu_win_t [NUM_WIN-1:0] act_q  [2];

  for (genvar d = 0; d < 2; d++) begin : g_dir
    for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
      atu_win #(.INIT_EN(d == 1 && w == 0)) u_win (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (reg_wr && fld_ok && cur_in == 1'(d) && cur_win == WIN_W'(w)),
        .wr_fld (fld),
        .wdata  (reg_wdata),
        .prog   (prog_q[d][w]),
        .act    (act_q[d][w])
      );
    end
  end

  atu_win_t cur;
  assign cur = prog_q[cur_in][cur_win];

  always_ff @(posedge clk) begin
    if (rst || !reg_rd) begin
      reg_rdata <= '0;
    end else begin
      case (reg_addr)
        OFF_IDX:     reg_rdata <= {cur_in, {(31-WIN_W){1'b0}}, cur_win};
        OFF_BASE_LO: reg_rdata <= cur.base[31:0];
        OFF_BASE_HI: reg_rdata <= cur.base[63:32];
        OFF_TGT_LO:  reg_rdata <= cur.target[31:0];
        OFF_TGT_HI:  reg_rdata <= cur.target[63:32];
        OFF_LIMIT:   reg_rdata <= cur.limit;
        OFF_CTRL0:   reg_rdata <= cur.ctrl0;
        OFF_CTRL1:   reg_rdata <= cur.ctrl1;
        default:     reg_rdata <= '0;
      endcase
    end
  end

  logic             l_hit, l_cfg;
  logic [WIN_W-1:0] l_win;
  logic [63:0]      l_addr;
  logic [7:0]       l_bus, l_devfn;

  atu_lookup #(.NUM_WIN(NUM_WIN), .CFG_OFF_W(CFG_OFF_W)) u_lookup (
    .wins  (lk_inbound ? act_q[1] : act_q[0]),
    .addr  (lk_addr),
    .hit   (l_hit),
    .win   (l_win),
    .cfg   (l_cfg),
    .xaddr (l_addr),
    .bus   (l_bus),
    .devfn (l_devfn)
  );

  always_ff @(posedge clk) begin
    if (rst || !lk_valid) begin
      res_valid <= 1'b0;
      res_hit   <= 1'b0;
      res_cfg   <= 1'b0;
      res_win   <= '0;
      res_addr  <= '0;
      res_bus   <= '0;
      res_devfn <= '0;
    end else begin
      res_valid <= 1'b1;
      res_hit   <= l_hit;
      res_cfg   <= l_cfg;
      res_win   <= l_win;
      res_addr  <= l_addr;
      res_bus   <= l_bus;
      res_devfn <= l_devfn;
    end
  end

  // R1: index write stores masked window number and bank flag
  p_idx_store_r1: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && reg_addr == OFF_IDX) |=>
      (cur_win == ($past(reg_wdata[WIN_W-1:0]) & WIN_MASK) && cur_in == $past(reg_wdata[DIR_BIT])));
  // R12: result valid follows a request by one cycle
  p_valid_lat_r12: assert property (@(posedge clk) disable iff (rst)
    lk_valid |=> res_valid);
  p_hit_needs_valid_r12: assert property (@(posedge clk) disable iff (rst)
    res_hit |-> res_valid);
  // R7: configuration offsets stay inside the configuration space
  p_cfg_off_r7: assert property (@(posedge clk) disable iff (rst)
    (res_hit && res_cfg) |-> res_addr[63:CFG_OFF_W] == '0);
  // R10: a miss drives quiet outputs
  p_miss_quiet_r10: assert property (@(posedge clk) disable iff (rst)
    (res_valid && !res_hit) |-> (res_addr == '0 && !res_cfg && res_bus == '0 && res_devfn == '0));
endmodule

// File: tb/tb_atu_xlate_regs.sv
module tb_atu_xlate_regs;
  localparam int CLK_PERIOD = 10;
  localparam int NW = 16;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [5:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        lk_valid = 1'b0, lk_inbound = 1'b0;
  logic [63:0] lk_addr = '0;
  logic        res_valid, res_hit, res_cfg;
  logic [3:0]  res_win;
  logic [63:0] res_addr;
  logic [7:0]  res_bus, res_devfn;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  atu_xlate_regs #(.NUM_WIN(NW), .CFG_OFF_W(12)) dut (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .lk_valid(lk_valid),
    .lk_inbound(lk_inbound), .lk_addr(lk_addr), .res_valid(res_valid),
    .res_hit(res_hit), .res_cfg(res_cfg), .res_win(res_win), .res_addr(res_addr),
    .res_bus(res_bus), .res_devfn(res_devfn)
  );

  task automatic check(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd_chk(input logic [5:0] a, input logic [31:0] exp, input string req);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a;
    @(negedge clk);
    reg_rd = 1'b0;
    check(req, $sformatf("read off %0d", a), 64'(reg_rdata), 64'(exp));
  endtask

  task automatic pick(input bit inb, input int w);
    wr(6'd0, {inb, 27'd0, 4'(w)});
  endtask

  task automatic look(input bit inb, input logic [63:0] a, input bit eh, input bit ec,
                      input int ew, input logic [63:0] ea, input logic [7:0] eb,
                      input logic [7:0] ed, input string req);
    @(negedge clk);
    lk_valid = 1'b1; lk_inbound = inb; lk_addr = a;
    @(negedge clk);
    lk_valid = 1'b0;
    check("R12", "res_valid", 64'(res_valid), 64'd1);
    check(req, $sformatf("hit @%0h", a), 64'(res_hit), 64'(eh));
    check(req, $sformatf("addr @%0h", a), res_addr, ea);
    check(req, $sformatf("cfg @%0h", a), 64'(res_cfg), 64'(ec));
    if (eh) check(req, $sformatf("win @%0h", a), 64'(res_win), 64'(ew));
    check(req, $sformatf("bus @%0h", a), 64'(res_bus), 64'(eb));
    check(req, $sformatf("devfn @%0h", a), 64'(res_devfn), 64'(ed));
  endtask

  task automatic t_reset;
    rd_chk(6'd0, 32'h0, "R4");
    check("R12", "res_valid idle", 64'(res_valid), 64'd0);
    pick(1'b1, 0);
    rd_chk(6'd5, 32'hFFFF_FFFF, "R4");
    rd_chk(6'd6, 32'h0, "R4");
    rd_chk(6'd7, 32'h8000_0000, "R4");
    rd_chk(6'd1, 32'h0, "R4");
    pick(1'b0, 0);
    rd_chk(6'd7, 32'h0, "R4");
    look(1'b1, 64'h1234, 1, 0, 0, 64'h1234, 0, 0, "R4");
    look(1'b0, 64'h1234, 0, 0, 0, 64'h0, 0, 0, "R10");
    look(1'b1, 64'h1_0000_0000, 0, 0, 0, 64'h0, 0, 0, "R5");
  endtask

  task automatic t_index;
    wr(6'd0, 32'h8000_003F);
    rd_chk(6'd0, 32'h8000_000F, "R1");
    wr(6'd0, 32'h7FFF_FFF2);
    rd_chk(6'd0, 32'h0000_0002, "R1");
    rd_chk(6'd12, 32'h0, "R11");
  endtask

  task automatic t_halves;
    pick(1'b0, 2);
    wr(6'd1, 32'h0000_1000);
    wr(6'd2, 32'h0000_00AB);
    rd_chk(6'd1, 32'h0000_1000, "R3");
    rd_chk(6'd2, 32'h0000_00AB, "R3");
    wr(6'd2, 32'h0);
    wr(6'd4, 32'h0000_0002);
    wr(6'd3, 32'h5000_0000);
    rd_chk(6'd4, 32'h0000_0002, "R3");
  endtask

  task automatic t_memory;
    wr(6'd5, 32'h0000_1FFF);
    wr(6'd6, 32'h0);
    look(1'b0, 64'h1000, 0, 0, 0, 64'h0, 0, 0, "R8");
    wr(6'd7, 32'h8000_0000);
    look(1'b0, 64'h1000, 1, 0, 2, 64'h2_5000_0000, 0, 0, "R6");
    look(1'b0, 64'h1FFF, 1, 0, 2, 64'h2_5000_0FFF, 0, 0, "R5");
    look(1'b0, 64'h2000, 0, 0, 0, 64'h0, 0, 0, "R5");
    look(1'b0, 64'h0FFF, 0, 0, 0, 64'h0, 0, 0, "R5");
  endtask

  task automatic t_staging;
    wr(6'd3, 32'h6000_0000);
    look(1'b0, 64'h1010, 1, 0, 2, 64'h2_5000_0010, 0, 0, "R8");
    wr(6'd7, 32'h8000_0000);
    look(1'b0, 64'h1010, 1, 0, 2, 64'h2_6000_0010, 0, 0, "R8");
  endtask

  task automatic t_priority;
    pick(1'b0, 5);
    wr(6'd1, 32'h0000_1800);
    wr(6'd5, 32'h0000_27FF);
    wr(6'd3, 32'h9000_0000);
    wr(6'd7, 32'h8000_0000);
    look(1'b0, 64'h1900, 1, 0, 2, 64'h2_6000_0900, 0, 0, "R9");
    look(1'b0, 64'h2100, 1, 0, 5, 64'h9000_0900, 0, 0, "R9");
    pick(1'b0, 2);
    wr(6'd7, 32'h0);
    look(1'b0, 64'h1900, 1, 0, 5, 64'h9000_0100, 0, 0, "R9");
  endtask

  task automatic t_config;
    pick(1'b0, 7);
    wr(6'd1, 32'h4000_0000);
    wr(6'd5, 32'h4FFF_FFFF);
    wr(6'd3, 32'h0312_0000);
    wr(6'd6, 32'h0000_0004);
    wr(6'd7, 32'h8000_0000);
    look(1'b0, 64'h4000_1ABC, 1, 1, 7, 64'h0ABC, 8'h03, 8'h12, "R7");
  endtask

  task automatic t_banks;
    look(1'b1, 64'h1900, 1, 0, 0, 64'h1900, 0, 0, "R10");
    pick(1'b1, 5);
    rd_chk(6'd1, 32'h0, "R2");
    rd_chk(6'd3, 32'h0, "R2");
    pick(1'b0, 5);
    rd_chk(6'd1, 32'h0000_1800, "R2");
    rd_chk(6'd3, 32'h9000_0000, "R2");
  endtask

  task automatic finish_run;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_index();
    t_halves();
    t_memory();
    t_staging();
    t_priority();
    t_config();
    t_banks();
    finish_run();
  end
endmodule